// File: doc/BRIEF.md
# Parabolic Step Calibration Search

This sequencer looks for the value of one signed correction setting that minimises an energy reading taken from outside the block. At each trial it places a candidate value on its output word, asks for one energy measurement over a request/acknowledge pair, and uses the returned figure. Each iteration takes three readings: one at the current base value, one a fixed step above it and one a fixed step below it. From these three readings it fits a parabola and moves the base toward the estimated minimum.

A single instance serves two searches. In gain mode it sweeps the gain correction while the phase correction is held at an external value. In phase mode the roles are swapped. The candidate and the held value are packed into one 32-bit trial word, which downstream logic applies to the transmit path. When the search finishes, the block reports the converged value together with a one-cycle done strobe.

Top module: `parab_cal_search`

## Requirements
- R1: After reset meas_req, done and busy are low, and trial_word and result are zero.
- R2: An iteration measures at base, then base+4, then base-4. The base starts at 0. In gain mode trial_word[15:0] holds the candidate and trial_word[31:16] holds hold_val. In phase mode trial_word[31:16] holds the candidate and trial_word[15:0] holds hold_val.
- R3: Measurements use a four-phase handshake with one outstanding request. meas_req rises only while meas_ack is low and stays high until meas_ack is seen. The energy is taken while both are high. The next request waits until meas_ack has fallen.
- R4: With curvature C = E+ − 2·E0 + E− > 0, the adjustment is trunc(trunc((E+ − E−)·4 / C) / 2), capped from above at 16.
- R5: With C ≤ 0 the adjustment is 0 and the iteration limit grows by one. Once the limit exceeds 8, the search ends with the base unchanged.
- R6: If base − adjustment would lie outside [−60, 60], the adjustment becomes 0. Otherwise the new base is base − adjustment.
- R7: From the second iteration on, a base reading above the previous iteration's base reading adds the last applied adjustment back to the base and measures the base again before probing.
- R8: Any base reading (first or repeated) below 50 ends the search at once with the current base.
- R9: The starting iteration limit is 6 in gain mode and 4 in phase mode. The previous-energy register starts at 1048576.
- R10: The search ends with done high for exactly one cycle, busy low, and result holding the final base.
- R11: start and phase_mode are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when idle |
| phase_mode | input | 1 | 0 = search gain, 1 = search phase |
| hold_val | input | 16 | Signed value kept for the other parameter |
| meas_req | output | 1 | Measurement request |
| meas_ack | input | 1 | Measurement acknowledge |
| meas_energy | input | 24 | Unsigned energy, valid with meas_ack |
| trial_word | output | 32 | Packed candidate and held value |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Signed converged value |

## Verification
Any fault in the base, the stored adjustment or the previous-energy register changes the next trial word. The reference model predicts every trial word, so such a fault shows up at the very next measurement request rather than only in the final result. A wrong curvature sign or a wrong limit count changes how many requests are made and when done arrives. A fault in the divider or the cap shifts the base of the following iteration. Energy shapes are chosen so that the revert, the cap, the range clip, the flat-curvature extension and the low-energy exit each decide the sequence.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS,
    ST_DIV,
    ST_UPD
  } pss_state_e;

  typedef enum logic [1:0] {
    TG_BASE,
    TG_REDO,
    TG_PLUS,
    TG_MINUS
  } pss_tag_e;
endpackage

// File: rtl/pss_meas_hs.sv
module pss_meas_hs #(
  parameter int E_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           ack,
  input  logic [E_W-1:0] energy,
  output logic           req,
  output logic           fin,
  output logic [E_W-1:0] data
);
  logic wait_rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req        <= 1'b0;
      wait_rel_q <= 1'b0;
      fin        <= 1'b0;
      data       <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !req && !wait_rel_q) begin
        req <= 1'b1;
      end else if (req && ack) begin
        req        <= 1'b0;
        data       <= energy;
        wait_rel_q <= 1'b1;
      end else if (wait_rel_q && !ack) begin
        wait_rel_q <= 1'b0;
        fin        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_divider.sv
module pss_divider #(
  parameter int NW = 27,
  parameter int QB = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          done,
  output logic [QB-1:0] quo
);
  localparam int XW = NW + QB;
  localparam int CNTW = $clog2(QB) + 1;

  logic [NW-1:0]   rem_q;
  logic [XW-1:0]   dsh_q;
  logic [CNTW-1:0] cnt_q;
  logic            run_q;
  logic            fits_w;

  assign fits_w = XW'(rem_q) >= dsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dsh_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (XW'(num) >= (XW'(den) << QB)) begin
          quo  <= '1;
          done <= 1'b1;
        end else begin
          rem_q <= num;
          dsh_q <= XW'(den) << (QB - 1);
          cnt_q <= CNTW'(QB - 1);
          quo   <= '0;
          run_q <= 1'b1;
        end
      end else if (run_q) begin
        if (fits_w) rem_q <= rem_q - dsh_q[NW-1:0];
        quo   <= {quo[QB-2:0], fits_w};
        dsh_q <= dsh_q >> 1;
        if (cnt_q == '0) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/parab_cal_search.sv
module parab_cal_search #(
  parameter int E_W        = 24,
  parameter int V_W        = 16,
  parameter int STEP       = 4,
  parameter int CAP_MUL    = 4,
  parameter int RANGE      = 60,
  parameter int LOW_E      = 50,
  parameter int ITER_GAIN  = 6,
  parameter int ITER_PHASE = 4,
  parameter int LIMIT_MAX  = 8,
  parameter int PREV_INIT  = 1048576,
  parameter int QBITS      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             phase_mode,
  input  logic [V_W-1:0]   hold_val,
  output logic             meas_req,
  input  logic             meas_ack,
  input  logic [E_W-1:0]   meas_energy,
  output logic [2*V_W-1:0] trial_word,
  output logic             busy,
  output logic             done,
  output logic [V_W-1:0]   result
);
  import pss_pkg::*;

  localparam int CW  = E_W + 2;
  localparam int NW  = E_W + 3;
  localparam int LW  = $clog2(LIMIT_MAX + 2) + 1;
  localparam int CAP = CAP_MUL * STEP;

  typedef logic [E_W-1:0]        en_t;
  typedef logic signed [V_W-1:0] val_t;

  function automatic logic [2*V_W-1:0] pack_f(logic ph, val_t hold, val_t v);
    return ph ? {v, hold} : {hold, v};
  endfunction

  function automatic logic signed [CW-1:0] curv_f(en_t ep, en_t e0, en_t em);
    logic signed [CW-1:0] sp, sm, s0;
    sp = $signed({2'b00, ep});
    sm = $signed({2'b00, em});
    s0 = $signed({2'b00, e0});
    return sp + sm - (s0 <<< 1);
  endfunction

  function automatic logic signed [NW-1:0] numer_f(en_t ep, en_t em);
    logic signed [NW-1:0] d;
    d = $signed({3'b000, ep}) - $signed({3'b000, em});
    return d * $signed(NW'(STEP));
  endfunction

  function automatic val_t adj_f(logic neg, logic [QBITS-1:0] q);
    val_t m;
    m = val_t'(q >> 1);
    if (neg) return -m;
    return (m > val_t'(CAP)) ? val_t'(CAP) : m;
  endfunction

  function automatic logic out_of_range_f(val_t v);
    return (v > val_t'(RANGE)) || (v < -val_t'(RANGE));
  endfunction

  pss_state_e state_q;
  pss_tag_e   tag_q;
  logic       mode_q;
  val_t       hold_q, base_q, adj_q, adj_new_q, probe_q, result_q;
  en_t        e0_q, ep_q, prev_q;
  logic [LW-1:0] iter_q, lim_q;
  logic [2*V_W-1:0] trial_q;
  logic       issue_q, done_q, div_go_q, neg_q;
  logic [NW-1:0] div_num_q, div_den_q;

  logic          hs_fin;
  en_t           hs_data;
  logic          div_done;
  logic [QBITS-1:0] div_quo;

  logic signed [CW-1:0] curv_w;
  logic signed [NW-1:0] numer_w;
  val_t revert_val_w, plus_val_w, minus_val_w, upd_a_w, upd_base_w;

  // Named internal events, observed by the bound checker
  logic ev_low_w, ev_revert_w, ev_flat_w, ev_stop_w, ev_clip_w;

  pss_meas_hs #(.E_W(E_W)) u_hs (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (issue_q),
    .ack    (meas_ack),
    .energy (meas_energy),
    .req    (meas_req),
    .fin    (hs_fin),
    .data   (hs_data)
  );

  pss_divider #(.NW(NW), .QB(QBITS)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_go_q),
    .num   (div_num_q),
    .den   (div_den_q),
    .done  (div_done),
    .quo   (div_quo)
  );

  assign curv_w       = curv_f(ep_q, e0_q, hs_data);
  assign numer_w      = numer_f(ep_q, hs_data);
  assign revert_val_w = base_q + adj_q;
  assign plus_val_w   = base_q + val_t'(STEP);
  assign minus_val_w  = base_q - val_t'(STEP);
  assign ev_clip_w    = (state_q == ST_UPD) && out_of_range_f(base_q - adj_new_q);
  assign upd_a_w      = ev_clip_w ? '0 : adj_new_q;
  assign upd_base_w   = base_q - upd_a_w;

  assign ev_low_w    = (state_q == ST_MEAS) && hs_fin &&
                       ((tag_q == TG_BASE) || (tag_q == TG_REDO)) &&
                       (hs_data < en_t'(LOW_E));
  assign ev_revert_w = (state_q == ST_MEAS) && hs_fin && (tag_q == TG_BASE) &&
                       !ev_low_w && (iter_q != '0) && (hs_data > prev_q);
  assign ev_flat_w   = (state_q == ST_MEAS) && hs_fin && (tag_q == TG_MINUS) &&
                       !(curv_w > 0);
  assign ev_stop_w   = (state_q == ST_UPD) && (lim_q > LW'(LIMIT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tag_q     <= TG_BASE;
      mode_q    <= 1'b0;
      hold_q    <= '0;
      base_q    <= '0;
      adj_q     <= '0;
      adj_new_q <= '0;
      probe_q   <= '0;
      result_q  <= '0;
      e0_q      <= '0;
      ep_q      <= '0;
      prev_q    <= en_t'(PREV_INIT);
      iter_q    <= '0;
      lim_q     <= '0;
      trial_q   <= '0;
      issue_q   <= 1'b0;
      done_q    <= 1'b0;
      div_go_q  <= 1'b0;
      neg_q     <= 1'b0;
      div_num_q <= '0;
      div_den_q <= '0;
    end else begin
      issue_q  <= 1'b0;
      done_q   <= 1'b0;
      div_go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q  <= phase_mode;
            hold_q  <= hold_val;
            base_q  <= '0;
            adj_q   <= '0;
            prev_q  <= en_t'(PREV_INIT);
            iter_q  <= '0;
            lim_q   <= phase_mode ? LW'(ITER_PHASE) : LW'(ITER_GAIN);
            probe_q <= '0;
            trial_q <= pack_f(phase_mode, hold_val, '0);
            tag_q   <= TG_BASE;
            issue_q <= 1'b1;
            state_q <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (hs_fin) begin
            unique case (tag_q)
              TG_BASE, TG_REDO: begin
                e0_q <= hs_data;
                if (ev_low_w) begin
                  result_q <= base_q;
                  done_q   <= 1'b1;
                  state_q  <= ST_IDLE;
                end else if (ev_revert_w) begin
                  base_q  <= revert_val_w;
                  probe_q <= revert_val_w;
                  trial_q <= pack_f(mode_q, hold_q, revert_val_w);
                  tag_q   <= TG_REDO;
                  issue_q <= 1'b1;
                end else begin
                  probe_q <= plus_val_w;
                  trial_q <= pack_f(mode_q, hold_q, plus_val_w);
                  tag_q   <= TG_PLUS;
                  issue_q <= 1'b1;
                end
              end
              TG_PLUS: begin
                ep_q    <= hs_data;
                probe_q <= minus_val_w;
                trial_q <= pack_f(mode_q, hold_q, minus_val_w);
                tag_q   <= TG_MINUS;
                issue_q <= 1'b1;
              end
              TG_MINUS: begin
                if (curv_w > 0) begin
                  neg_q     <= numer_w < 0;
                  div_num_q <= (numer_w < 0) ? NW'(-numer_w) : NW'(numer_w);
                  div_den_q <= NW'(curv_w);
                  div_go_q  <= 1'b1;
                  state_q   <= ST_DIV;
                end else begin
                  adj_new_q <= '0;
                  lim_q     <= lim_q + 1'b1;
                  state_q   <= ST_UPD;
                end
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        ST_DIV: begin
          if (div_done) begin
            adj_new_q <= adj_f(neg_q, div_quo);
            state_q   <= ST_UPD;
          end
        end
        ST_UPD: begin
          if (ev_stop_w) begin
            result_q <= base_q;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            base_q <= upd_base_w;
            adj_q  <= upd_a_w;
            prev_q <= e0_q;
            if ((iter_q + 1'b1) >= lim_q) begin
              result_q <= upd_base_w;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              iter_q  <= iter_q + 1'b1;
              probe_q <= upd_base_w;
              trial_q <= pack_f(mode_q, hold_q, upd_base_w);
              tag_q   <= TG_BASE;
              issue_q <= 1'b1;
              state_q <= ST_MEAS;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trial_word = trial_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign result     = result_q;
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int V_W       = 16,
  parameter int RANGE     = 60,
  parameter int STEP      = 4,
  parameter int LIMIT_MAX = 8,
  parameter int LW        = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  meas_req,
  input logic                  meas_ack,
  input logic                  done,
  input logic                  busy,
  input logic signed [V_W-1:0] result,
  input logic signed [V_W-1:0] probe,
  input logic [LW-1:0]         lim,
  input logic                  ev_flat
);
  // R3: request held until acknowledged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !meas_ack) |=> meas_req);

  // R3: a new request starts only after acknowledge has dropped
  assert_req_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_req) |-> !meas_ack);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result <= RANGE) && (result >= -RANGE)));

  assert_probe_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> ((probe <= RANGE + STEP) && (probe >= -(RANGE + STEP))));

  assert_flat_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flat |=> (lim == $past(lim) + 1'b1));

  assert_limit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lim <= LW'(LIMIT_MAX + 1)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !meas_req);
endmodule

bind parab_cal_search pss_checker #(
  .V_W(V_W), .RANGE(RANGE), .STEP(STEP), .LIMIT_MAX(LIMIT_MAX), .LW(LW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .meas_req (meas_req),
  .meas_ack (meas_ack),
  .done     (done),
  .busy     (busy),
  .result   (result),
  .probe    (probe_q),
  .lim      (lim_q),
  .ev_flat  (ev_flat_w)
);

// File: tb/parab_cal_search_tb.sv
module parab_cal_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        phase_mode = 1'b0;
  logic [15:0] hold_val = '0;
  logic        meas_req;
  logic        meas_ack = 1'b0;
  logic [23:0] meas_energy = '0;
  logic [31:0] trial_word;
  logic        busy, done;
  logic [15:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int exp_res;
  int exp_cnt;

  always #5 clk = ~clk;

  parab_cal_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_mode(phase_mode),
    .hold_val(hold_val), .meas_req(meas_req), .meas_ack(meas_ack),
    .meas_energy(meas_energy), .trial_word(trial_word), .busy(busy),
    .done(done), .result(result)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint energy(int sc, int v);
    case (sc)
      1: return 10 * (v - 8) * (v - 8) + 1000;
      2: return 3 * (v + 13) * (v + 13) + 200;
      3: return v * v + 10;
      4: return 1000;
      5: return (v + 200) * (v + 200);
      default: return (v < 10) ? ((v - 10) * (v - 10) + 60) : (100 * (v - 10) * (v - 10) + 60);
    endcase
  endfunction

  // Behavioural reference of the search: list of trial values and result
  task automatic model(input int sc, input bit ph);
    int base, adj, lim, k, a;
    longint prev, e0, ep, em, c, n, q;
    exp_q.delete();
    base = 0; adj = 0; k = 0; prev = 1048576;
    lim = ph ? 4 : 6;
    while (k < lim) begin
      exp_q.push_back(base); e0 = energy(sc, base);
      if (e0 < 50) break;
      if (k > 0 && e0 > prev) begin
        base += adj;
        exp_q.push_back(base); e0 = energy(sc, base);
        if (e0 < 50) break;
      end
      exp_q.push_back(base + 4); ep = energy(sc, base + 4);
      exp_q.push_back(base - 4); em = energy(sc, base - 4);
      c = ep - 2 * e0 + em;
      if (c > 0) begin
        n = (ep - em) * 4;
        q = n / c;
        a = int'(q / 2);
        if (a > 16) a = 16;
      end else begin
        a = 0;
        lim++;
      end
      if (lim > 8) break;
      if (base - a > 60 || base - a < -60) a = 0;
      base -= a; adj = a; prev = e0; k++;
    end
    exp_res = base;
    exp_cnt = exp_q.size();
  endtask

  task automatic run(input int sc, input bit ph, input int hold, input int pulse_at,
                     input string tag, output int got_res, output int got_cnt);
    int idx, v, guard;
    logic [31:0] ew;
    bit fin;
    model(sc, ph);
    @(negedge clk);
    phase_mode = ph; hold_val = hold[15:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; fin = 0; guard = 0; got_res = 0;
    while (!fin && guard < 20000) begin
      guard++;
      if (done) begin
        fin = 1;
        got_res = int'($signed(result));
        check(int'($signed(result)) == exp_res, {tag, " result R10"}, int'($signed(result)), exp_res);
        @(negedge clk);
        check(!done && !busy, "done one-cycle R10", done, 0);
      end else if (meas_req && !meas_ack) begin
        v = (exp_q.size() > 0) ? exp_q.pop_front() : 9999;
        ew = ph ? {v[15:0], hold[15:0]} : {hold[15:0], v[15:0]};
        check(trial_word == ew, {tag, " trial word R2"}, trial_word, ew);
        for (int d = 0; d < (idx % 3) + 1; d++) begin
          if (idx == pulse_at && d == 0) begin start = 1'b1; phase_mode = ~ph; end
          @(negedge clk);
          start = 1'b0; phase_mode = ph;
          check(meas_req == 1'b1, "req held before ack R3", meas_req, 1);
        end
        meas_energy = 24'(energy(sc, v));
        meas_ack = 1'b1;
        @(negedge clk);
        check(meas_req == 1'b0, "req drops after ack R3", meas_req, 0);
        meas_ack = 1'b0;
        meas_energy = '0;
        idx++;
      end
      if (!fin) @(negedge clk);
    end
    got_cnt = idx;
    check(idx == exp_cnt, {tag, " measurement count R9"}, idx, exp_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r, c;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!meas_req && !done && !busy, "reset outputs R1", {meas_req, done, busy}, 0);
    check(trial_word == 0 && result == 0, "reset words R1", trial_word, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(1, 0, 7, -1, "gain quadratic R4", r, c);
    check(r == 8, "gain converges to 8 R4", r, 8);
    run(2, 1, -5, -1, "phase quadratic R9", r, c);
    run(3, 0, 3, -1, "low energy R8", r, c);
    check(c == 1 && r == 0, "early exit after one reading R8", c, 1);
    run(4, 0, 0, -1, "flat gain R5", r, c);
    check(c == 9 && r == 0, "flat gain stops after 3 iterations R5", c, 9);
    run(4, 1, 0, -1, "flat phase R9", r, c);
    check(c == 15, "flat phase stops after 5 iterations R9", c, 15);
    run(5, 0, 1, -1, "cap and clip R6", r, c);
    check(r == -48, "capped steps then range clip R4 R6", r, -48);
    run(6, 1, 2, -1, "asymmetric revert R7", r, c);
    check(c > 12, "revert adds repeated base readings R7", c, 13);
    run(1, 0, 7, 2, "start while busy R11", r, c);
    check(r == 8, "busy start ignored R11", r, 8);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule